// File: doc/BRIEF.md
# Learned Transmitter Record Table Manager

This block keeps the list of remote transmitters that a receiver has learned. The list lives in a small nonvolatile memory outside the block, which it reaches through a synchronous port of 16-bit words. Each transmitter takes one fixed-size record. The record holds the button code used while learning, the 28-bit serial number and two copies of the 16-bit synchronisation counter.

A controller issues one of four commands with a single-cycle start pulse while the block is idle:
- Look up a serial number.
- Add a new transmitter into the lowest free slot.
- Rewrite the counter of the record last located.
- Wipe the whole table.

Lookups walk the table from slot 0 in order, so their latency grows with the position of the record. Free slots are recognised by a reserved value in the first record byte, not by a separate valid bit.

When a lookup hits, the block returns the stored counter. It also raises a flag if the two copies of the counter disagree.

Top module: `tx_table_mgr`

## Requirements
- R1: Record r occupies byte addresses r*8 to r*8+7, and the table holds MAX_REC records (default 16). Word k of record r is read or written at the even byte address r*8+2k. Read data is valid on `mem_rdata_i` in the cycle after `mem_re_o` is high.
- R2: Word 0 of a record is {func[3:0], serial[27:24], serial[7:0]}. Word 1 is {serial[15:8], serial[23:16]}.
- R3: Words 2 and 3 each hold the 16-bit counter, with the high byte in bits 15:8. An insert writes all four words and puts `sync_i` in both counter words.
- R4: A slot is empty exactly when bits 15:8 of its word 0 equal 8'hF0.
- R5: Command 0 (search) checks slots in ascending order from slot 0 and skips empty slots. It stops at the first slot whose 28-bit serial equals `serial_i`, then reports `found_o`=1 and sets `index_o` to that slot. With no match, `found_o`=0 and `index_o` keeps its previous value.
- R6: Command 1 (insert) writes the record into the lowest-numbered empty slot and sets `index_o` to that slot. If no slot is empty, it sets `full_o`=1 and writes nothing to memory.
- R7: Command 2 (update) writes `sync_i` into words 2 and 3 of slot `index_o`, and into no other word.
- R8: Command 3 (erase) writes 16'hF000 into word 0 of every slot. Afterwards no search hits, and the next insert goes to slot 0.
- R9: On a search hit, `sync_o` equals word 2 of the slot. `mismatch_o` is 1 exactly when word 2 differs from word 3.
- R10: `start_i` is taken only while `busy_o` is 0; a start pulse during a command has no effect. `busy_o` rises in the cycle after the accepted start and stays high until `done_o`. `done_o` is a single-cycle pulse, and the status outputs are valid while it is high.
- R11: After reset, `busy_o`, `done_o`, `found_o`, `full_o` and `mismatch_o` are 0, and `index_o` is 0.
- R12: A search compares all 28 serial bits and ignores the function code. A record whose serial differs only in bits 27:24 does not match.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Command start pulse, taken when idle |
| cmd_i | input | 2 | 0 search, 1 insert, 2 update, 3 erase |
| serial_i | input | 28 | Serial number for search and insert |
| func_i | input | 4 | Function code stored by insert |
| sync_i | input | 16 | Counter value for insert and update |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | Command finished, status valid |
| found_o | output | 1 | Search hit |
| full_o | output | 1 | Insert found no empty slot |
| mismatch_o | output | 1 | Counter copies differ in the hit record |
| index_o | output | 4 | Slot of the last hit or insert |
| sync_o | output | 16 | Stored counter of the hit record |
| mem_re_o | output | 1 | Memory read request |
| mem_we_o | output | 1 | Memory write request |
| mem_addr_o | output | 7 | Byte address, always even |
| mem_wdata_o | output | 16 | Memory write data |
| mem_rdata_i | input | 16 | Memory read data, one cycle after the request |

## Verification
Two situations are hard to reach through the command interface alone, because a correct design never creates them: diverging counter copies, and an empty slot sitting before live records. The bench therefore alters its own memory model between commands. It corrupts one counter copy and clears the marker of slot 0. It then confirms that the lookup reports the mismatch, skips the cleared slot, and that the next insert reuses it.

The full-table case needs every slot occupied first. The bench fills the remaining slots, tries one more insert, and compares a snapshot of the whole memory taken before that insert.

A second start pulse is injected while a long scan of the last slot is running.

// File: rtl/tx_table_pkg.sv
package tx_table_pkg;
  localparam int unsigned REC_BYTES = 8;
  localparam int unsigned REC_WORDS = REC_BYTES / 2;
  localparam int unsigned WRD_W     = $clog2(REC_WORDS);
  localparam logic [7:0]  EMPTY_TAG = 8'hF0;

  typedef enum logic [1:0] {
    CMD_SEARCH = 2'd0,
    CMD_INSERT = 2'd1,
    CMD_UPDATE = 2'd2,
    CMD_ERASE  = 2'd3
  } tbl_cmd_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_SRD0, ST_SCK0,
    ST_SRD1, ST_SCK1,
    ST_SRD2, ST_SCK2,
    ST_SRD3, ST_SCK3,
    ST_IRD,  ST_ICK,
    ST_WR,
    ST_ERW,
    ST_FIN
  } tbl_state_e;
endpackage

// File: rtl/tx_rec_codec.sv
module tx_rec_codec
  import tx_table_pkg::*;
(
  input  logic [27:0]      serial_i,
  input  logic [3:0]       func_i,
  input  logic [15:0]      sync_i,
  input  logic [WRD_W-1:0] wrd_i,
  input  logic [15:0]      rdata_i,
  output logic [15:0]      wdata_o,
  output logic             empty_o,
  output logic             id0_hit_o,
  output logic             id1_hit_o
);
  always_comb begin
    unique case (wrd_i)
      2'd0:    wdata_o = {func_i, serial_i[27:24], serial_i[7:0]};
      2'd1:    wdata_o = {serial_i[15:8], serial_i[23:16]};
      default: wdata_o = sync_i;
    endcase
  end

  assign empty_o   = (rdata_i[15:8] == EMPTY_TAG);
  assign id0_hit_o = (rdata_i[11:8] == serial_i[27:24]) && (rdata_i[7:0] == serial_i[7:0]);
  assign id1_hit_o = (rdata_i == {serial_i[15:8], serial_i[23:16]});
endmodule

// File: rtl/tx_rec_cursor.sv
module tx_rec_cursor
  import tx_table_pkg::*;
#(
  parameter int unsigned MAX_REC = 16,
  localparam int unsigned REC_W  = $clog2(MAX_REC)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rec_clr_i,
  input  logic             rec_inc_i,
  input  logic             rec_load_i,
  input  logic [REC_W-1:0] rec_val_i,
  input  logic             wrd_set_i,
  input  logic [WRD_W-1:0] wrd_val_i,
  input  logic             wrd_inc_i,
  output logic [REC_W-1:0] rec_o,
  output logic [WRD_W-1:0] wrd_o,
  output logic             rec_last_o,
  output logic             wrd_last_o
);
  logic [REC_W-1:0] rec_q;
  logic [WRD_W-1:0] wrd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rec_q <= '0;
    end else if (rec_clr_i) begin
      rec_q <= '0;
    end else if (rec_load_i) begin
      rec_q <= rec_val_i;
    end else if (rec_inc_i) begin
      rec_q <= rec_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wrd_q <= '0;
    end else if (wrd_set_i) begin
      wrd_q <= wrd_val_i;
    end else if (wrd_inc_i) begin
      wrd_q <= wrd_q + 1'b1;
    end
  end

  assign rec_o      = rec_q;
  assign wrd_o      = wrd_q;
  assign rec_last_o = (rec_q == REC_W'(MAX_REC - 1));
  assign wrd_last_o = (wrd_q == WRD_W'(REC_WORDS - 1));

  // R1: record walk never steps past the last slot
  assert_rec_no_wrap_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_inc_i |-> !rec_last_o);
  // R3: a record write burst never runs past word 3
  assert_wrd_no_wrap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrd_inc_i |-> !wrd_last_o);
endmodule

// File: rtl/tx_table_mgr.sv
module tx_table_mgr
  import tx_table_pkg::*;
#(
  parameter int unsigned MAX_REC  = 16,
  localparam int unsigned REC_W   = $clog2(MAX_REC),
  localparam int unsigned ADDR_W  = REC_W + WRD_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [1:0]        cmd_i,
  input  logic [27:0]       serial_i,
  input  logic [3:0]        func_i,
  input  logic [15:0]       sync_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              found_o,
  output logic              full_o,
  output logic              mismatch_o,
  output logic [REC_W-1:0]  index_o,
  output logic [15:0]       sync_o,
  output logic              mem_re_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [15:0]       mem_wdata_o,
  input  logic [15:0]       mem_rdata_i
);
  tbl_state_e state_q, state_d;
  tbl_cmd_e   cmd_q;
  logic [27:0] serial_q;
  logic [3:0]  func_q;
  logic [15:0] sync_q, copy_q;
  logic [REC_W-1:0] index_q;
  logic found_q, full_q, mism_q;

  logic rec_clr, rec_inc, rec_load, wrd_set, wrd_inc;
  logic [REC_W-1:0] rec;
  logic [WRD_W-1:0] wrd, wrd_val, acc_wrd;
  logic rec_last, wrd_last;
  logic [15:0] enc_data;
  logic empty, id0_hit, id1_hit;
  logic set_found, set_full, set_slot;

  tx_rec_cursor #(.MAX_REC(MAX_REC)) u_cursor (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rec_clr_i  (rec_clr),
    .rec_inc_i  (rec_inc),
    .rec_load_i (rec_load),
    .rec_val_i  (index_q),
    .wrd_set_i  (wrd_set),
    .wrd_val_i  (wrd_val),
    .wrd_inc_i  (wrd_inc),
    .rec_o      (rec),
    .wrd_o      (wrd),
    .rec_last_o (rec_last),
    .wrd_last_o (wrd_last)
  );

  tx_rec_codec u_codec (
    .serial_i  (serial_q),
    .func_i    (func_q),
    .sync_i    (sync_q),
    .wrd_i     (acc_wrd),
    .rdata_i   (mem_rdata_i),
    .wdata_o   (enc_data),
    .empty_o   (empty),
    .id0_hit_o (id0_hit),
    .id1_hit_o (id1_hit)
  );

  always_comb begin
    state_d   = state_q;
    rec_clr   = 1'b0;
    rec_inc   = 1'b0;
    rec_load  = 1'b0;
    wrd_set   = 1'b0;
    wrd_val   = '0;
    wrd_inc   = 1'b0;
    set_found = 1'b0;
    set_full  = 1'b0;
    set_slot  = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        unique case (tbl_cmd_e'(cmd_i))
          CMD_SEARCH: begin rec_clr = 1'b1; state_d = ST_SRD0; end
          CMD_INSERT: begin rec_clr = 1'b1; state_d = ST_IRD;  end
          CMD_UPDATE: begin
            rec_load = 1'b1;
            wrd_set  = 1'b1;
            wrd_val  = WRD_W'(2);
            state_d  = ST_WR;
          end
          CMD_ERASE:  begin rec_clr = 1'b1; state_d = ST_ERW;  end
          default:    state_d = ST_IDLE;
        endcase
      end
      ST_SRD0: state_d = ST_SCK0;
      ST_SCK0: begin
        if (empty || !id0_hit) begin
          if (rec_last) state_d = ST_FIN;
          else begin rec_inc = 1'b1; state_d = ST_SRD0; end
        end else begin
          state_d = ST_SRD1;
        end
      end
      ST_SRD1: state_d = ST_SCK1;
      ST_SCK1: begin
        if (!id1_hit) begin
          if (rec_last) state_d = ST_FIN;
          else begin rec_inc = 1'b1; state_d = ST_SRD0; end
        end else begin
          state_d = ST_SRD2;
        end
      end
      ST_SRD2: state_d = ST_SCK2;
      ST_SCK2: state_d = ST_SRD3;
      ST_SRD3: state_d = ST_SCK3;
      ST_SCK3: begin set_found = 1'b1; state_d = ST_FIN; end
      ST_IRD:  state_d = ST_ICK;
      ST_ICK: begin
        if (empty) begin
          set_slot = 1'b1;
          wrd_set  = 1'b1;
          wrd_val  = '0;
          state_d  = ST_WR;
        end else if (rec_last) begin
          set_full = 1'b1;
          state_d  = ST_FIN;
        end else begin
          rec_inc = 1'b1;
          state_d = ST_IRD;
        end
      end
      ST_WR: begin
        if (wrd_last) state_d = ST_FIN;
        else wrd_inc = 1'b1;
      end
      ST_ERW: begin
        if (rec_last) state_d = ST_FIN;
        else rec_inc = 1'b1;
      end
      ST_FIN:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      cmd_q    <= CMD_SEARCH;
      serial_q <= '0;
      func_q   <= '0;
      sync_q   <= '0;
      copy_q   <= '0;
      index_q  <= '0;
      found_q  <= 1'b0;
      full_q   <= 1'b0;
      mism_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && start_i) begin
        cmd_q    <= tbl_cmd_e'(cmd_i);
        serial_q <= serial_i;
        func_q   <= func_i;
        sync_q   <= sync_i;
        found_q  <= 1'b0;
        full_q   <= 1'b0;
        mism_q   <= 1'b0;
      end
      if (state_q == ST_SCK2) copy_q <= mem_rdata_i;
      if (set_found) begin
        found_q <= 1'b1;
        mism_q  <= (copy_q != mem_rdata_i);
        index_q <= rec;
      end
      if (set_slot) index_q <= rec;
      if (set_full) full_q  <= 1'b1;
    end
  end

  always_comb begin
    unique case (state_q)
      ST_SRD1: acc_wrd = WRD_W'(1);
      ST_SRD2: acc_wrd = WRD_W'(2);
      ST_SRD3: acc_wrd = WRD_W'(3);
      ST_WR:   acc_wrd = wrd;
      default: acc_wrd = '0;
    endcase
  end

  assign mem_re_o    = (state_q inside {ST_SRD0, ST_SRD1, ST_SRD2, ST_SRD3, ST_IRD});
  assign mem_we_o    = (state_q inside {ST_WR, ST_ERW});
  assign mem_addr_o  = {rec, acc_wrd, 1'b0};
  assign mem_wdata_o = (state_q == ST_ERW) ? {EMPTY_TAG, 8'h00} : enc_data;

  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = (state_q == ST_FIN);
  assign found_o    = found_q;
  assign full_o     = full_q;
  assign mismatch_o = mism_q;
  assign index_o    = index_q;
  assign sync_o     = copy_q;

  // R10: handshake
  assert_busy_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o) |=> busy_o);
  assert_done_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_busy_from_start_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i));
  // R6: a full report never carries a hit
  assert_full_no_found_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && full_o) |-> !found_o);
  // R9: mismatch only alongside a hit
  assert_mismatch_hit_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mismatch_o |-> found_o);
  // R7: update touches only the counter words
  assert_update_words_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && cmd_q == CMD_UPDATE) |-> mem_addr_o[2]);
  // R1: a bus cycle is either read or write
  assert_rw_excl_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_we_o && mem_re_o));
endmodule

// File: tb/tx_table_mgr_bench.sv
`timescale 1ns/1ps
module tx_table_mgr_bench;
  localparam int NW = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        start = 1'b0;
  logic [1:0]  cmd = 2'd0;
  logic [27:0] serial = '0;
  logic [3:0]  func = '0;
  logic [15:0] sync = '0;
  logic busy, done, found, full, mism;
  logic [3:0]  index;
  logic [15:0] sync_rd;
  logic mem_re, mem_we;
  logic [6:0]  mem_addr;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata = '0;

  logic [15:0] mem [NW];
  logic [15:0] snap [NW];
  logic        poke_en = 1'b0;
  logic [5:0]  poke_idx = '0;
  logic [15:0] poke_dat = '0;

  int checks = 0;
  int errors = 0;

  tx_table_mgr u_tx_table_mgr (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .cmd_i(cmd),
    .serial_i(serial), .func_i(func), .sync_i(sync),
    .busy_o(busy), .done_o(done), .found_o(found), .full_o(full),
    .mismatch_o(mism), .index_o(index), .sync_o(sync_rd),
    .mem_re_o(mem_re), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata)
  );

  always @(posedge clk) begin
    if (poke_en) mem[poke_idx] <= poke_dat;
    else if (mem_we) mem[mem_addr[6:1]] <= mem_wdata;
    if (mem_re) mem_rdata <= mem[mem_addr[6:1]];
  end

  typedef struct {
    string       tag;
    logic        found;
    logic        full;
    logic        mism;
    logic [3:0]  idx;
    logic [15:0] sync;
  } exp_t;
  exp_t exq[$];

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // monitor: compare each completion against the queued expectation
  initial begin
    forever begin
      @(negedge clk);
      if (done) begin
        if (exq.size() == 0) begin
          chk("R10", "unexpected done", 32'd1, 32'd0);
        end else begin
          exp_t e;
          e = exq.pop_front();
          chk(e.tag, "found", {31'd0, found}, {31'd0, e.found});
          chk(e.tag, "full", {31'd0, full}, {31'd0, e.full});
          chk(e.tag, "mismatch", {31'd0, mism}, {31'd0, e.mism});
          chk(e.tag, "index", {28'd0, index}, {28'd0, e.idx});
          if (e.found) chk(e.tag, "sync", {16'd0, sync_rd}, {16'd0, e.sync});
        end
      end
    end
  end

  task automatic run(input logic [1:0] c, input logic [27:0] s, input logic [3:0] f,
                     input logic [15:0] y, input string tag, input logic ef, input logic efu,
                     input logic em, input logic [3:0] ei, input logic [15:0] es);
    exp_t e;
    e.tag = tag; e.found = ef; e.full = efu; e.mism = em; e.idx = ei; e.sync = es;
    exq.push_back(e);
    @(negedge clk);
    cmd = c; serial = s; func = f; sync = y; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R10", "busy after start", {31'd0, busy}, 32'd1);
    while (!done) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic poke(input int w, input logic [15:0] d);
    @(negedge clk);
    poke_en = 1'b1; poke_idx = 6'(w); poke_dat = d;
    @(negedge clk);
    poke_en = 1'b0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  localparam logic [27:0] SER_A = 28'hA5C3E71;
  localparam logic [27:0] SER_B = 28'h0012345;
  localparam logic [27:0] SER_C = 28'h35C3E71;
  localparam logic [27:0] SER_D = 28'h7777777;

  initial begin
    for (int i = 0; i < NW; i++) mem[i] = 16'h5555;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11", "busy", {31'd0, busy}, 32'd0);
    chk("R11", "done", {31'd0, done}, 32'd0);
    chk("R11", "flags", {29'd0, found, full, mism}, 32'd0);
    chk("R11", "index", {28'd0, index}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R8 erase marks every slot empty (R4 marker F0 in bits 15:8 of word 0)
    run(2'd3, '0, '0, '0, "R8", 1'b0, 1'b0, 1'b0, 4'd0, '0);
    for (int r = 0; r < 16; r++) chk("R8", "word0 after erase", {16'd0, mem[r*4]}, 32'h0000F000);

    // R6/R2/R3 inserts fill lowest slots
    run(2'd1, SER_A, 4'h2, 16'h1234, "R6", 1'b0, 1'b0, 1'b0, 4'd0, '0);
    chk("R2", "A word0", {16'd0, mem[0]}, 32'h00002A71);
    chk("R2", "A word1", {16'd0, mem[1]}, 32'h00003E5C);
    chk("R3", "A word2", {16'd0, mem[2]}, 32'h00001234);
    chk("R3", "A word3", {16'd0, mem[3]}, 32'h00001234);
    run(2'd1, SER_B, 4'h1, 16'h0F0F, "R6", 1'b0, 1'b0, 1'b0, 4'd1, '0);
    run(2'd1, SER_C, 4'h4, 16'hBEEF, "R6", 1'b0, 1'b0, 1'b0, 4'd2, '0);
    chk("R1", "C word0 at byte 16", {16'd0, mem[8]}, 32'h00004371);

    // R12 serial differing only in top nibble: C found at slot 2, not A
    run(2'd0, SER_C, 4'h0, '0, "R12", 1'b1, 1'b0, 1'b0, 4'd2, 16'hBEEF);
    // R5/R9 hit on slot 0
    run(2'd0, SER_A, 4'h0, '0, "R5", 1'b1, 1'b0, 1'b0, 4'd0, 16'h1234);
    // R5 miss leaves index unchanged
    run(2'd0, 28'h1111111, 4'h0, '0, "R5", 1'b0, 1'b0, 1'b0, 4'd0, '0);

    // R7 update rewrites counter words of slot 0 only
    run(2'd2, '0, '0, 16'h1300, "R7", 1'b0, 1'b0, 1'b0, 4'd0, '0);
    chk("R7", "word2", {16'd0, mem[2]}, 32'h00001300);
    chk("R7", "word3", {16'd0, mem[3]}, 32'h00001300);
    chk("R7", "word0 kept", {16'd0, mem[0]}, 32'h00002A71);
    run(2'd0, SER_A, 4'h0, '0, "R7", 1'b1, 1'b0, 1'b0, 4'd0, 16'h1300);

    // R9 corrupt second copy of slot 1
    poke(7, 16'h0F0E);
    run(2'd0, SER_B, 4'h0, '0, "R9", 1'b1, 1'b0, 1'b1, 4'd1, 16'h0F0F);

    // R5 skip empty: mark slot 0 free, A no longer found; R6 insert reuses slot 0
    poke(0, 16'hF000);
    run(2'd0, SER_A, 4'h0, '0, "R5", 1'b0, 1'b0, 1'b0, 4'd1, '0);
    run(2'd1, SER_D, 4'h8, 16'h0042, "R6", 1'b0, 1'b0, 1'b0, 4'd0, '0);

    // fill slots 3..15
    for (int i = 0; i < 13; i++)
      run(2'd1, 28'h0100000 + 28'(i), 4'h1, 16'h2000 + 16'(i), "R6",
          1'b0, 1'b0, 1'b0, 4'(3 + i), '0);
    // R6 full: no write
    for (int i = 0; i < NW; i++) snap[i] = mem[i];
    run(2'd1, 28'h0ABCDEF, 4'h1, 16'h9999, "R6", 1'b0, 1'b1, 1'b0, 4'd15, '0);
    begin
      int diff = 0;
      for (int i = 0; i < NW; i++) if (mem[i] !== snap[i]) diff++;
      chk("R6", "words changed when full", 32'(diff), 32'd0);
    end

    // R10 start while busy is ignored
    begin
      exp_t e;
      e.tag = "R10"; e.found = 1'b1; e.full = 1'b0; e.mism = 1'b0;
      e.idx = 4'd15; e.sync = 16'h200C;
      exq.push_back(e);
      @(negedge clk);
      cmd = 2'd0; serial = 28'h010000C; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (4) @(negedge clk);
      cmd = 2'd3; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      while (!done) @(negedge clk);
      repeat (6) @(negedge clk);
      chk("R10", "idle after ignored start", {31'd0, busy}, 32'd0);
      chk("R10", "slot 0 not erased", {16'd0, mem[0]}, 32'h00008777);
    end
    run(2'd0, SER_D, 4'h0, '0, "R10", 1'b1, 1'b0, 1'b0, 4'd0, 16'h0042);

    // R8 erase then search misses and insert lands in slot 0
    run(2'd3, '0, '0, '0, "R8", 1'b0, 1'b0, 1'b0, 4'd0, '0);
    run(2'd0, SER_B, 4'h0, '0, "R8", 1'b0, 1'b0, 1'b0, 4'd0, '0);
    run(2'd1, SER_C, 4'h3, 16'h0001, "R8", 1'b0, 1'b0, 1'b0, 4'd0, '0);
    chk("R8", "queue drained", 32'(exq.size()), 32'd0);
    finish_run();
  end
endmodule